// File: doc/BRIEF.md
# External Interrupt Sense and Latch

This block turns eight external interrupt pins and one non-maskable interrupt pin into held request bits for a downstream priority arbiter. Every pin is first brought into the clock domain through a two-flop synchronizer. Each of the eight maskable pins has its own 2-bit sense mode, chosen from low level, high level, falling edge and rising edge. The non-maskable pin is always edge-detected, and a single polarity bit selects which edge.

A level-sensed request does not follow the pin. Once it is caught, it stays pending after the pin goes back to inactive. It is released when the CPU side signals that any interrupt was accepted, or when its mask bit is set. An edge-sensed request stays pending until its own clear strobe arrives. When the non-maskable polarity bit is written, edges on that pin are ignored for the next six clock edges. This keeps the write itself from producing a false detection.

Configuration arrives through three write strobes with data: all mode fields in one write, all mask bits in one write, and the non-maskable polarity bit. Acknowledgement arrives as an accept pulse, a per-source clear vector and a non-maskable clear pulse.

Top module: `irq_sense_latch`

## Requirements
- R1: Reset clears every pending request, sets every sense mode to 00 (low level), sets every mask bit to 1 and selects the falling edge for the non-maskable pin.
- R2: Mode 00 detects low level and mode 11 detects high level. A request from a pin that reaches its active level shows on `irq_req` at the third rising clock edge after the change, and not at the second.
- R3: Mode 01 detects a falling edge and mode 10 detects a rising edge, with the same three-edge latency. The opposite transition latches nothing.
- R4: A level-mode request stays pending after its pin returns to the inactive level. The per-source clear strobe has no effect on it.
- R5: A one-cycle `accept` pulse releases every level-mode pending request on the next edge. It has no effect on edge-mode requests.
- R6: An edge-mode request is cleared only by its own bit of `irq_clr`. A clear that coincides with a new qualifying edge on the same pin leaves the request pending.
- R7: A mask bit of 1 clears its request by the second edge after the mask write and blocks any new request on that pin while it stays set.
- R8: The non-maskable pin sets `nmi_req` on a falling edge when the polarity bit is 0 and on a rising edge when it is 1. It ignores the mask bits and is cleared by `nmi_clr`.
- R9: On the six clock edges that follow a polarity write, non-maskable edges are ignored; detection resumes on the seventh edge. Each new write restarts the six-edge window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin | input | 8 | Asynchronous maskable interrupt pins |
| nmi_pin | input | 1 | Asynchronous non-maskable interrupt pin |
| mode_we | input | 1 | Write strobe for all sense modes |
| mode_wdata | input | 16 | Sense modes, pin i in bits 2i+1:2i |
| mask_we | input | 1 | Write strobe for the mask bits |
| mask_wdata | input | 8 | Mask bits, 1 = masked |
| nmi_pol_we | input | 1 | Write strobe for the non-maskable polarity |
| nmi_pol_wdata | input | 1 | Polarity, 1 = rising, 0 = falling |
| accept | input | 1 | Pulse: CPU accepted an interrupt |
| irq_clr | input | 8 | Per-source clear pulses for edge-mode requests |
| nmi_clr | input | 1 | Clear pulse for the non-maskable request |
| irq_req | output | 8 | Pending maskable requests |
| nmi_req | output | 1 | Pending non-maskable request |

## Verification
The bench sweeps all four sense modes across all eight pins, one pin at a time. Each pin is driven to its active level or edge and back. This separates channels that share logic, and it shows whether a request clears with the pin level (wrong), with accept (level modes only) or with its own clear bit (edge modes only). Per-mode group tests then fire all pins at once under accept, and time a clear against a fresh edge, which tells clear-wins from set-wins. The non-maskable pin is tried with both polarities, with edges timed to land just inside and just outside the blanking window, and with a second polarity write made inside the window.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_FALL = 2'b01,
        SENSE_RISE = 2'b10,
        SENSE_HIGH = 2'b11
    } sense_mode_e;

    localparam int unsigned SYNC_DEPTH = 2;
    localparam int unsigned NMI_BLANK  = 6;
    localparam int unsigned BLANK_W    = $clog2(NMI_BLANK + 1);

    // Synchronized pin value now and one cycle earlier
    typedef struct packed {
        logic now;
        logic prev;
    } pin_view_t;

    function automatic logic is_level(sense_mode_e m);
        return (m == SENSE_LOW) || (m == SENSE_HIGH);
    endfunction

    function automatic logic level_active(sense_mode_e m, logic v);
        return (m == SENSE_HIGH) ? v : ~v;
    endfunction

    function automatic logic edge_hit(logic rising, pin_view_t p);
        return rising ? (p.now & ~p.prev) : (~p.now & p.prev);
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int unsigned WIDTH = 1,
    parameter int unsigned DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_now,
    output logic [WIDTH-1:0] sync_prev
);
    // stages 0..DEPTH-1 synchronize; stage DEPTH holds the previous value
    logic [WIDTH-1:0] stage [DEPTH+1];

    genvar k;
    generate
        for (k = 0; k <= DEPTH; k++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage[k] <= '0;
                end else begin
                    if (k == 0) stage[k] <= async_in;
                    else        stage[k] <= stage[(k == 0) ? 0 : k-1];
                end
            end
        end
    endgenerate

    assign sync_now  = stage[DEPTH-1];
    assign sync_prev = stage[DEPTH];
endmodule

// File: rtl/irq_chan.sv
module irq_chan
    import irq_sense_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  sense_mode_e mode,
    input  logic        mask,
    input  pin_view_t   view,
    input  logic        accept,
    input  logic        clr,
    output logic        pend
);
    logic level_mode;
    logic hit;

    always_comb begin
        level_mode = is_level(mode);
        hit        = level_mode ? level_active(mode, view.now)
                                : edge_hit(mode == SENSE_RISE, view);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
        end else if (mask) begin
            pend <= 1'b0;
        end else if (level_mode) begin
            pend <= accept ? 1'b0 : (pend | hit);
        end else begin
            pend <= hit | (pend & ~clr);
        end
    end

    AST_MASK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        mask |=> !pend); // R7

    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (is_level(mode) && pend && !accept && !mask) |=> pend); // R4

    AST_ACCEPT_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (is_level(mode) && accept) |=> !pend); // R5

    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!is_level(mode) && pend && !clr && !mask) |=> pend); // R6

    AST_EDGE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!is_level(mode) && !pend && (view.now == view.prev)) |=> !pend); // R3
endmodule

// File: rtl/nmi_detect.sv
module nmi_detect
    import irq_sense_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pol_we,
    input  logic      pol_wdata,
    input  pin_view_t view,
    input  logic      clr,
    output logic      pend
);
    logic               rising_q;
    logic [BLANK_W-1:0] blank_cnt;
    logic               open_win;
    logic               hit;

    always_comb begin
        open_win = (blank_cnt == '0);
        hit      = edge_hit(rising_q, view) & open_win;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rising_q  <= 1'b0;
            blank_cnt <= '0;
            pend      <= 1'b0;
        end else begin
            if (pol_we) begin
                rising_q  <= pol_wdata;
                blank_cnt <= BLANK_W'(NMI_BLANK);
            end else if (!open_win) begin
                blank_cnt <= blank_cnt - 1'b1;
            end
            pend <= hit | (pend & ~clr);
        end
    end

    AST_BLANK_LOAD: assert property (@(posedge clk) disable iff (rst)
        pol_we |=> (blank_cnt == BLANK_W'(NMI_BLANK))); // R9

    AST_BLANK_NO_RISE: assert property (@(posedge clk) disable iff (rst)
        (blank_cnt != '0) |=> !$rose(pend)); // R9

    AST_NMI_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pend && !clr) |=> pend); // R8
endmodule

// File: rtl/irq_sense_latch.sv
module irq_sense_latch
    import irq_sense_pkg::*;
#(
    parameter int unsigned NUM_PINS = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_PINS-1:0]   irq_pin,
    input  logic                  nmi_pin,
    input  logic                  mode_we,
    input  logic [2*NUM_PINS-1:0] mode_wdata,
    input  logic                  mask_we,
    input  logic [NUM_PINS-1:0]   mask_wdata,
    input  logic                  nmi_pol_we,
    input  logic                  nmi_pol_wdata,
    input  logic                  accept,
    input  logic [NUM_PINS-1:0]   irq_clr,
    input  logic                  nmi_clr,
    output logic [NUM_PINS-1:0]   irq_req,
    output logic                  nmi_req
);
    localparam int unsigned SYNC_W = NUM_PINS + 1;

    logic [SYNC_W-1:0]   s_now;
    logic [SYNC_W-1:0]   s_prev;
    sense_mode_e         mode_q [NUM_PINS];
    logic [NUM_PINS-1:0] mask_q;

    irq_sync #(
        .WIDTH (SYNC_W),
        .DEPTH (SYNC_DEPTH)
    ) u_sync (
        .clk       (clk),
        .rst       (rst),
        .async_in  ({nmi_pin, irq_pin}),
        .sync_now  (s_now),
        .sync_prev (s_prev)
    );

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '1;
        else if (mask_we) mask_q <= mask_wdata;
    end

    genvar i;
    generate
        for (i = 0; i < NUM_PINS; i++) begin : g_chan
            always_ff @(posedge clk) begin
                if (rst) mode_q[i] <= SENSE_LOW;
                else if (mode_we) mode_q[i] <= sense_mode_e'(mode_wdata[2*i +: 2]);
            end

            pin_view_t view;
            assign view = '{now: s_now[i], prev: s_prev[i]};

            irq_chan u_chan (
                .clk    (clk),
                .rst    (rst),
                .mode   (mode_q[i]),
                .mask   (mask_q[i]),
                .view   (view),
                .accept (accept),
                .clr    (irq_clr[i]),
                .pend   (irq_req[i])
            );
        end
    endgenerate

    pin_view_t nmi_view;
    assign nmi_view = '{now: s_now[NUM_PINS], prev: s_prev[NUM_PINS]};

    nmi_detect u_nmi (
        .clk       (clk),
        .rst       (rst),
        .pol_we    (nmi_pol_we),
        .pol_wdata (nmi_pol_wdata),
        .view      (nmi_view),
        .clr       (nmi_clr),
        .pend      (nmi_req)
    );

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (irq_req == '0 && !nmi_req)); // R1
endmodule

// File: tb/irq_sense_latch_bench.sv
`timescale 1ns/100ps
module irq_sense_latch_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  irq_pin;
    logic        nmi_pin;
    logic        mode_we;
    logic [15:0] mode_wdata;
    logic        mask_we;
    logic [7:0]  mask_wdata;
    logic        nmi_pol_we;
    logic        nmi_pol_wdata;
    logic        accept;
    logic [7:0]  irq_clr;
    logic        nmi_clr;
    logic [7:0]  irq_req;
    logic        nmi_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_sense_latch u_irq_sense_latch (
        .clk(clk), .rst(rst), .irq_pin(irq_pin), .nmi_pin(nmi_pin),
        .mode_we(mode_we), .mode_wdata(mode_wdata),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .nmi_pol_we(nmi_pol_we), .nmi_pol_wdata(nmi_pol_wdata),
        .accept(accept), .irq_clr(irq_clr), .nmi_clr(nmi_clr),
        .irq_req(irq_req), .nmi_req(nmi_req)
    );

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_vec(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s irq_req actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic chk_nmi(string tag, logic exp);
        checks++;
        if (nmi_req !== exp) begin
            errors++;
            $display("FAIL %s nmi_req actual %0b expected %0b", tag, nmi_req, exp);
        end
    endtask

    task automatic write_mask(logic [7:0] m);
        mask_we = 1'b1; mask_wdata = m;
        tick(1);
        mask_we = 1'b0;
        tick(1);
    endtask

    task automatic pulse_accept();
        accept = 1'b1; tick(1); accept = 1'b0;
    endtask

    task automatic pulse_clr(logic [7:0] c);
        irq_clr = c; tick(1); irq_clr = '0;
    endtask

    task automatic write_pol(logic p);
        nmi_pol_we = 1'b1; nmi_pol_wdata = p; tick(1); nmi_pol_we = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; irq_pin = 8'hFF; nmi_pin = 1'b1;
        mode_we = 0; mode_wdata = '0; mask_we = 0; mask_wdata = '0;
        nmi_pol_we = 0; nmi_pol_wdata = 0; accept = 0; irq_clr = '0; nmi_clr = 0;
        tick(3);
        rst = 1'b0;
        tick(1);
        chk_vec("R1 reset", irq_req, 8'h00);
        chk_nmi("R1 reset", 1'b0);

        // R1: masked after reset, so active-low pins latch nothing
        irq_pin = 8'h00; tick(4);
        chk_vec("R1 masked at reset", irq_req, 8'h00);
        // unmask: reset mode is low level, so every pin latches
        write_mask(8'h00);
        chk_vec("R1 reset mode low level", irq_req, 8'hFF);
        write_mask(8'hFF);
        chk_vec("R7 mask all", irq_req, 8'h00);
        irq_pin = 8'hFF; tick(4);

        // Non-maskable pin, masks all set (R8 ignores masks)
        nmi_pin = 1'b0; tick(2);
        chk_nmi("R8 latency not yet", 1'b0);
        tick(1);
        chk_nmi("R8 falling edge at reset polarity", 1'b1);
        nmi_clr = 1'b1; tick(1); nmi_clr = 1'b0;
        chk_nmi("R8 clear", 1'b0);
        nmi_pin = 1'b1; tick(4);
        chk_nmi("R8 rising ignored in falling polarity", 1'b0);
        nmi_pin = 1'b0; tick(4);
        nmi_clr = 1'b1; tick(1); nmi_clr = 1'b0;
        chk_nmi("R8 clear again", 1'b0);

        // R9: rising edge right after write, blanked
        write_pol(1'b1);
        nmi_pin = 1'b1; tick(8);
        chk_nmi("R9 edge right after write", 1'b0);
        nmi_pin = 1'b0; tick(4);
        chk_nmi("R8 falling ignored in rising polarity", 1'b0);

        // R9: detection edge lands on sixth edge after write: blanked
        write_pol(1'b1);
        tick(3);
        nmi_pin = 1'b1; tick(6);
        chk_nmi("R9 sixth edge blanked", 1'b0);
        nmi_pin = 1'b0; tick(4);

        // R9: detection edge lands on seventh edge: seen
        write_pol(1'b1);
        tick(4);
        nmi_pin = 1'b1; tick(3);
        chk_nmi("R9 seventh edge detected", 1'b1);
        nmi_clr = 1'b1; tick(1); nmi_clr = 1'b0;
        nmi_pin = 1'b0; tick(4);
        chk_nmi("R8 cleared", 1'b0);

        // R9: second write restarts window
        write_pol(1'b1);
        tick(2);
        write_pol(1'b1);
        tick(3);
        nmi_pin = 1'b1; tick(6);
        chk_nmi("R9 reload on second write", 1'b0);
        nmi_pin = 1'b0; tick(4);

        // Sweep over modes and pins
        for (int m = 0; m < 4; m++) begin
            logic [1:0] mv;
            logic idle;
            bit level;
            mv = 2'(m);
            level = (m == 0) || (m == 3);
            idle = (m == 0) || (m == 1);
            write_mask(8'hFF);
            mode_we = 1'b1; mode_wdata = {8{mv}}; tick(1); mode_we = 1'b0;
            irq_pin = {8{idle}}; tick(4);
            write_mask(8'h00);
            chk_vec(level ? "R2 idle" : "R3 idle", irq_req, 8'h00);

            for (int i = 0; i < 8; i++) begin
                logic [7:0] bitv;
                bitv = 8'(1) << i;
                irq_pin[i] = ~idle; tick(2);
                chk_vec(level ? "R2 two edges" : "R3 two edges", irq_req, 8'h00);
                tick(1);
                chk_vec(level ? "R2 detect" : "R3 detect", irq_req, bitv);
                if (level) begin
                    irq_pin[i] = idle; tick(4);
                    chk_vec("R4 held after pin inactive", irq_req, bitv);
                    pulse_clr(8'hFF);
                    chk_vec("R4 clear strobe no effect", irq_req, bitv);
                    pulse_accept();
                    chk_vec("R5 accept releases level", irq_req, 8'h00);
                end else begin
                    pulse_accept();
                    chk_vec("R5 accept keeps edge", irq_req, bitv);
                    pulse_clr(~bitv);
                    chk_vec("R6 other clear bits", irq_req, bitv);
                    pulse_clr(bitv);
                    chk_vec("R6 own clear", irq_req, 8'h00);
                    irq_pin[i] = idle; tick(4);
                    chk_vec("R3 opposite edge", irq_req, 8'h00);
                end
                // R7: mask clears and blocks
                irq_pin[i] = ~idle; tick(3);
                chk_vec("R7 request before mask", irq_req, bitv);
                write_mask(bitv);
                chk_vec("R7 mask clears", irq_req, 8'h00);
                if (!level) begin
                    irq_pin[i] = idle; tick(4);
                    irq_pin[i] = ~idle; tick(4);
                end else begin
                    tick(3);
                end
                chk_vec("R7 mask blocks", irq_req, 8'h00);
                irq_pin[i] = idle; tick(4);
                write_mask(8'h00);
                chk_vec("R7 unmask quiet", irq_req, 8'h00);
            end

            // Group behaviour
            irq_pin = {8{~idle}}; tick(3);
            chk_vec(level ? "R2 all pins" : "R3 all pins", irq_req, 8'hFF);
            irq_pin = {8{idle}}; tick(4);
            if (level) begin
                chk_vec("R4 all held", irq_req, 8'hFF);
                pulse_accept();
                chk_vec("R5 accept releases all", irq_req, 8'h00);
            end else begin
                chk_vec("R6 all held", irq_req, 8'hFF);
                irq_pin[0] = ~idle; tick(2);
                pulse_clr(8'hFF);
                chk_vec("R6 new edge beats clear", irq_req, 8'h01);
                pulse_clr(8'hFF);
                chk_vec("R6 clear all", irq_req, 8'h00);
                irq_pin[0] = idle; tick(4);
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule